// File: doc/BRIEF.md
# Clock Frequency Meter

This block compares a monitored clock against a local reference clock. Software programs a control word with a monitored-source code, a reference prescale code and an enable bit. It then sets a start flag. The reference clock is divided by 1, 2, 4 or 8. The block opens a gate that lasts a fixed number of divided-reference periods and counts the rising edges of the monitored clock while the gate is open. When the count has settled, the block copies it into a read-only result word and lowers the start flag. Software polls the flag and then reads the count.

Three clock domains are involved: the bus, the reference and the monitored clock. The start request travels to the reference domain as a toggle. The gate travels to the monitored domain and comes back as an echo. Completion returns to the bus domain as a toggle. The bus side copies the count only after it has seen completion. If the source code is reserved or monitoring is disabled, the run finishes at once with a count of zero, so the flag always clears.

Top module: `fmeter`

## Requirements
- R1: After reset, the control word at offset 0x0 and the result word at offset 0x4 both read 0.
- R2: Writing 1 to control bit 8 while idle starts a run, and bit 8 then reads 1. Writing 0 to bit 8 never clears it. Only run completion clears it.
- R3: Bit 8 returns to 0 on the same bus edge at which the result word takes its new value.
- R4: The result word at offset 0x4 holds the count in bits [19:0], and bits [31:20] read 0. Writes to offset 0x4 are ignored. Any other offset reads 0.
- R5: With monitoring enabled and a valid source, the count equals the number of monitored rising edges in 256 divided-reference periods, within plus or minus 2.
- R6: Control bits [30:29] set the reference divide: 00 means 1, 01 means 2, 10 means 4 and 11 means 8. The count scales in proportion.
- R7: Control bits [23:22] select the source. Codes 00 and 11 both measure the monitored clock. Codes 01 and 10 are reserved: the run completes and the result is 0.
- R8: When control bit 31 (the monitor enable) is 0, a run completes and the result is 0.
- R9: A start written while a run is active is ignored. This includes a start that lands on the completion edge. The previous result stays readable until the next completion.
- R10: The count saturates at the all-ones value of the count width, which is 2^20-1 by default.
- R11: Control bits 31, [30:29] and [23:22] read back as written. All other control bits except bit 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| clk_ref | input | 1 | Reference clock that times the window |
| clk_mon | input | 1 | Monitored clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| bus_we | input | 1 | Write strobe, sampled on clk_bus |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Completion and a fresh start request can reach the bus register in the same clock edge. The bench provokes this by writing the start flag on every bus cycle until the flag reads 0. This guarantees that one write coincides with the completion edge. The bench then stops writing at once. A correct design stays idle after that point and holds the count of the first run. A design that accepts the coinciding write shows the flag set again.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;

   localparam int RES_W_MAX = 20;
   localparam int OFS_CTRL  = 0;
   localparam int OFS_RES   = 4;

   localparam int B_START   = 8;
   localparam int B_SEL_LO  = 22;
   localparam int B_DIV_LO  = 29;
   localparam int B_MEN     = 31;
   localparam int SEL_W     = 2;
   localparam int DIV_W     = 2;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_SETTLE,
      WS_WINDOW,
      WS_DRAIN,
      WS_REPORT
   } win_state_e;

   // Codes 00 and 11 route the monitored clock; 01 and 10 route nothing
   function automatic logic src_valid(input logic [SEL_W-1:0] sel);
      return (sel == 2'b00) || (sel == 2'b11);
   endfunction

endpackage

// File: rtl/fmeter_sync.sv
module fmeter_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fmeter_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fmeter_prescale.sv
module fmeter_prescale #(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   // Largest divide is 2**(2**CODE_W - 1); counter holds divide-1
   localparam int CW = (1 << CODE_W) - 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb lim = ~({CW{1'b1}} << code);

   assign tick = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/fmeter_window.sv
module fmeter_window
   import fmeter_pkg::*;
#(
   parameter int WIN_LOG2    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_tgl,
   input  logic [DIV_W-1:0] run_div,
   input  logic             run_valid,
   input  logic             echo_in,
   output logic             gate,
   output logic             done_tgl
);

   logic             req_s, req_d, echo_s, tick, presc_clr, seen_hi;
   logic [DIV_W-1:0] div_q;
   logic [WIN_LOG2-1:0] win_cnt;
   win_state_e       st;

   fmeter_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

   fmeter_sync #(.STAGES(SYNC_STAGES)) u_echo_sync (
      .clk(clk), .rst_n(rst_n), .d(echo_in), .q(echo_s));

   // Prescaler restarts at window entry so the window is exact
   assign presc_clr = (st != WS_WINDOW);

   fmeter_prescale #(.CODE_W(DIV_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .code(div_q), .tick(tick));

   // run_div and run_valid were set in the bus domain before the toggle
   // left it, so they are stable for several cycles when SETTLE samples them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= WS_IDLE;
         req_d    <= 1'b0;
         gate     <= 1'b0;
         done_tgl <= 1'b0;
         seen_hi  <= 1'b0;
         div_q    <= '0;
         win_cnt  <= '0;
      end else begin
         req_d <= req_s;
         unique case (st)
            WS_IDLE: begin
               if (req_s ^ req_d) st <= WS_SETTLE;
            end
            WS_SETTLE: begin
               div_q   <= run_div;
               win_cnt <= '0;
               seen_hi <= 1'b0;
               if (run_valid) begin
                  gate <= 1'b1;
                  st   <= WS_WINDOW;
               end else begin
                  st   <= WS_REPORT;
               end
            end
            WS_WINDOW: begin
               if (echo_s) seen_hi <= 1'b1;
               if (tick) begin
                  if (win_cnt == '1) begin
                     gate <= 1'b0;
                     st   <= WS_DRAIN;
                  end else begin
                     win_cnt <= win_cnt + 1'b1;
                  end
               end
            end
            WS_DRAIN: begin
               if (echo_s)       seen_hi <= 1'b1;
               else if (seen_hi) st <= WS_REPORT;
            end
            WS_REPORT: begin
               done_tgl <= ~done_tgl;
               st       <= WS_IDLE;
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fmeter_edge_count.sv
module fmeter_edge_count #(
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_in,
   output logic [CNT_W-1:0] cnt,
   output logic             echo
);

   logic gate_s, gate_d;

   fmeter_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_s));

   assign echo = gate_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         cnt    <= '0;
      end else begin
         gate_d <= gate_s;
         if (gate_s && !gate_d)       cnt <= CNT_W'(1);
         else if (gate_s && cnt != '1) cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fmeter.sv
module fmeter
   import fmeter_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CNT_W       = 20,
   parameter int WIN_LOG2    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_bus,
   input  logic              clk_ref,
   input  logic              clk_mon,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   if (CNT_W < 1 || CNT_W > RES_W_MAX) begin : g_bad_cnt
      $error("fmeter: CNT_W must lie in 1..20");
   end
   if (WIN_LOG2 < 1 || WIN_LOG2 > 16) begin : g_bad_win
      $error("fmeter: WIN_LOG2 must lie in 1..16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("fmeter: ADDR_W must be at least 3");
   end

   logic [SEL_W-1:0] cfg_sel;
   logic [DIV_W-1:0] cfg_div, run_div;
   logic             cfg_men, busy, run_valid, req_tgl;
   logic             done_tgl, done_s, done_d, done_evt;
   logic             gate, echo;
   logic [CNT_W-1:0] mon_cnt, result;
   logic             wr_ctrl, start_go;
   logic [31:0]      ctrl_word, res_word;
   logic             wdata_unused;

   assign wdata_unused = ^{bus_wdata[B_DIV_LO-1:B_SEL_LO+SEL_W],
                           bus_wdata[B_SEL_LO-1:B_START+1],
                           bus_wdata[B_START-1:0]};

   assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign start_go = wr_ctrl && bus_wdata[B_START] && !busy;

   fmeter_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk_bus), .rst_n(rst_n), .d(done_tgl), .q(done_s));

   assign done_evt = done_s ^ done_d;

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         cfg_sel   <= '0;
         cfg_div   <= '0;
         cfg_men   <= 1'b0;
         busy      <= 1'b0;
         run_valid <= 1'b0;
         run_div   <= '0;
         req_tgl   <= 1'b0;
         done_d    <= 1'b0;
         result    <= '0;
      end else begin
         done_d <= done_s;
         if (wr_ctrl) begin
            cfg_sel <= bus_wdata[B_SEL_LO +: SEL_W];
            cfg_div <= bus_wdata[B_DIV_LO +: DIV_W];
            cfg_men <= bus_wdata[B_MEN];
         end
         if (done_evt) begin
            busy   <= 1'b0;
            // Count in the monitored domain is frozen once completion is seen
            result <= run_valid ? mon_cnt : '0;
         end else if (start_go) begin
            busy      <= 1'b1;
            run_valid <= bus_wdata[B_MEN] &&
                         src_valid(bus_wdata[B_SEL_LO +: SEL_W]);
            run_div   <= bus_wdata[B_DIV_LO +: DIV_W];
            req_tgl   <= ~req_tgl;
         end
      end
   end

   fmeter_window #(.WIN_LOG2(WIN_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_window (
      .clk(clk_ref), .rst_n(rst_n), .req_tgl(req_tgl), .run_div(run_div),
      .run_valid(run_valid), .echo_in(echo), .gate(gate), .done_tgl(done_tgl));

   fmeter_edge_count #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_count (
      .clk(clk_mon), .rst_n(rst_n), .gate_in(gate), .cnt(mon_cnt), .echo(echo));

   always_comb begin
      ctrl_word                      = '0;
      ctrl_word[B_START]             = busy;
      ctrl_word[B_SEL_LO +: SEL_W]   = cfg_sel;
      ctrl_word[B_DIV_LO +: DIV_W]   = cfg_div;
      ctrl_word[B_MEN]               = cfg_men;
   end

   if (CNT_W == RES_W_MAX) begin : g_res_full
      assign res_word = {{(32-RES_W_MAX){1'b0}}, result};
   end else begin : g_res_narrow
      assign res_word = {{(32-CNT_W){1'b0}}, result};
   end

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))     bus_rdata = ctrl_word;
      else if (bus_addr == ADDR_W'(OFS_RES)) bus_rdata = res_word;
      else                                   bus_rdata = '0;
   end

endmodule

// File: rtl/fmeter_chk.sv
module fmeter_chk #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 20
) (
   input logic              clk_bus,
   input logic              clk_mon,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              busy,
   input logic              done_evt,
   input logic              run_valid,
   input logic [CNT_W-1:0]  result,
   input logic [CNT_W-1:0]  mon_cnt
);

   localparam logic [31:0] CTRL_RSVD = 32'h1F3F_FEFF;

   AST_HW_CLEAR_ONLY: assert property (@(posedge clk_bus) disable iff (!rst_n)
      busy && !done_evt |=> busy);                                    // R2

   AST_DONE_DROPS_BUSY: assert property (@(posedge clk_bus) disable iff (!rst_n)
      done_evt |=> !busy);                                            // R3

   AST_RESULT_HELD: assert property (@(posedge clk_bus) disable iff (!rst_n)
      !done_evt |=> $stable(result));                                 // R9

   AST_INVALID_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
      done_evt && !run_valid |=> result == '0);                       // R7

   AST_RES_UPPER_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
      bus_addr == ADDR_W'(4) |-> bus_rdata[31:20] == 12'h000);        // R4

   AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_bus) disable iff (!rst_n)
      bus_addr == ADDR_W'(0) |-> (bus_rdata & CTRL_RSVD) == 32'h0);   // R11

   AST_COUNT_SATURATES: assert property (@(posedge clk_mon) disable iff (!rst_n)
      mon_cnt == '1 |=> mon_cnt == '1 || mon_cnt == CNT_W'(1));       // R10

endmodule

bind fmeter fmeter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk_bus(clk_bus), .clk_mon(clk_mon), .rst_n(rst_n),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .busy(busy),
   .done_evt(done_evt), .run_valid(run_valid), .result(result),
   .mon_cnt(mon_cnt));

// File: tb/fmeter_test.sv
`timescale 1ns/1ps
module fmeter_test;

   localparam int SAT_W = 10;

   logic        clk_bus = 1'b0, clk_ref = 1'b0, clk_mon = 1'b0, rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, sat_rdata;
   real         mon_half = 1.0;

   int n_chk = 0, n_bad = 0, wd = 0;
   bit ended = 0;

   always #4 clk_bus = ~clk_bus;
   always #8 clk_ref = ~clk_ref;
   always #(mon_half) clk_mon = ~clk_mon;

   fmeter uut (
      .clk_bus(clk_bus), .clk_ref(clk_ref), .clk_mon(clk_mon), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata));

   fmeter #(.CNT_W(SAT_W)) uut_sat (
      .clk_bus(clk_bus), .clk_ref(clk_ref), .clk_mon(clk_mon), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(sat_rdata));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input longint act, input real lo, input real hi,
                            input real exp);
      chk(real'(act) >= lo && real'(act) <= hi, req, act, longint'(exp));
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk_bus);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk_bus);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] ds);
      bus_addr = a;
      #1;
      d  = bus_rdata;
      ds = sat_rdata;
   endtask

   task automatic wait_idle(output bit ok);
      logic [31:0] d, ds;
      ok = 0;
      for (int i = 0; i < 12000; i++) begin
         @(negedge clk_bus);
         rd(8'h0, d, ds);
         if (!d[8]) begin ok = 1; break; end
      end
   endtask

   function automatic logic [31:0] ctrl(input bit en, input int div, input int sel, input bit go);
      return (32'(en) << 31) | (32'(div) << 29) | (32'(sel) << 22) | (32'(go) << 8);
   endfunction

   task automatic measure(input int sel, input int div, input bit en, input real tmon);
      logic [31:0] d, ds, prev, prev_s, c;
      bit   ok, valid;
      real  exp, sexp, smax;
      string tag;
      valid = en && (sel == 0 || sel == 3);
      tag   = !en ? "R8" : (valid ? ((sel == 3) ? "R7/R6" : "R5/R6") : "R7");
      mon_half = tmon / 2.0;
      repeat (4) @(negedge clk_bus);
      rd(8'h4, prev, prev_s);
      c = ctrl(en, div, sel, 1'b1);
      wr(8'h0, c);
      rd(8'h0, d, ds);
      chk(d[8] == 1'b1, "R2 start flag set", d[8], 1);
      rd(8'h4, d, ds);
      chk(d == prev, "R9 result held while active", d, prev);
      if (valid) begin
         wr(8'h0, ctrl(en, div, sel, 1'b0));
         rd(8'h0, d, ds);
         chk(d[8] == 1'b1, "R2 zero write ignored", d[8], 1);
         wr(8'h0, c);
      end
      wait_idle(ok);
      chk(ok, "R3 run completes", ok, 1);
      rd(8'h4, d, ds);
      if (valid) begin
         exp  = 256.0 * real'(1 << div) * 16.0 / tmon;
         chk_range(tag, longint'(d), exp - 2.5, exp + 2.5, exp);
         smax = real'((1 << SAT_W) - 1);
         sexp = (exp > smax) ? smax : exp;
         chk_range("R10 saturating count", longint'(ds),
                   (exp - 2.5 > smax) ? smax : exp - 2.5,
                   (exp + 2.5 > smax) ? smax : exp + 2.5, sexp);
      end else begin
         chk(d == 32'h0, tag, d, 0);
         chk(ds == 32'h0, tag, ds, 0);
      end
      repeat (10) @(negedge clk_bus);
      rd(8'h0, d, ds);
      chk(d[8] == 1'b0, "R9 start while active dropped", d[8], 0);
   endtask

   initial begin
      while (!ended) begin
         @(posedge clk_bus);
         wd++;
         if (wd > 150000 && !ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] d, ds;
      bit ok;
      int n;
      repeat (10) @(negedge clk_bus);
      rst_n = 1'b1;
      repeat (4) @(negedge clk_bus);

      rd(8'h0, d, ds);
      chk(d == 32'h0, "R1 control after reset", d, 0);
      rd(8'h4, d, ds);
      chk(d == 32'h0, "R1 result after reset", d, 0);

      // Readback with every reserved bit set and the start bit clear
      wr(8'h0, 32'hFFFF_FEFF);
      rd(8'h0, d, ds);
      chk(d == 32'hE0C0_0000, "R11 readback", d, 32'hE0C0_0000);
      wr(8'h0, 32'h0);
      rd(8'h0, d, ds);
      chk(d == 32'h0, "R11 cleared readback", d, 0);

      wr(8'h4, 32'hFFFF_FFFF);
      rd(8'h4, d, ds);
      chk(d == 32'h0, "R4 result read-only", d, 0);
      wr(8'h8, 32'hFFFF_FFFF);
      rd(8'h8, d, ds);
      chk(d == 32'h0, "R4 unmapped offset", d, 0);
      rd(8'h0, d, ds);
      chk(d == 32'h0, "R4 unmapped write no effect", d, 0);

      // Sweep divide codes across three monitored periods
      foreach (d[i]) if (i < 3) begin
         real tm;
         tm = (i == 0) ? 2.0 : ((i == 1) ? 10.0 : 32.0);
         for (int dv = 0; dv < 4; dv++) measure((dv % 2) ? 3 : 0, dv, 1'b1, tm);
      end

      // Reserved source codes and disabled monitor
      measure(1, 0, 1'b1, 32.0);
      measure(2, 3, 1'b1, 32.0);
      measure(0, 1, 1'b0, 32.0);
      measure(3, 0, 1'b0, 32.0);

      // Valid run after a zero run publishes a count again
      measure(0, 0, 1'b1, 32.0);

      // Start written on every cycle, so one write meets the completion edge
      mon_half = 16.0;
      @(negedge clk_bus);
      bus_addr = 8'h0; bus_wdata = ctrl(1'b1, 0, 0, 1'b1); bus_we = 1'b1;
      @(negedge clk_bus);
      n = 0;
      while (n < 12000) begin
         #1;
         if (!bus_rdata[8]) break;
         @(negedge clk_bus);
         n++;
      end
      bus_we = 1'b0;
      chk(n < 12000, "R3 hammered run completes", n, 0);
      repeat (20) @(negedge clk_bus);
      rd(8'h0, d, ds);
      chk(d[8] == 1'b0, "R9 coinciding start dropped", d[8], 0);
      rd(8'h4, d, ds);
      chk_range("R9 hammered result", longint'(d), 125.5, 130.5, 128.0);
      chk(d[31:20] == 12'h0, "R4 upper bits zero", d[31:20], 0);

      wait_idle(ok);
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule